// File: doc/BRIEF.md
# Monochrome VGA Text Display Generator

This block drives a monitor through three pins: one video bit and active-low horizontal and vertical sync. It shows a grid of character cells, 32 wide by 16 tall by default. The picture comes from a character buffer with one byte per cell. A host fills that buffer through a plain write port, which has an address, a data byte and a write enable. A scan-timing counter sweeps a standard 640x480 frame of 800 clocks by 525 lines at a 25 MHz pixel clock, which gives about 60 Hz. A set of cell counters follows the beam. From them the block reads the cell's code, looks up the glyph row and shifts the selected pixel out.

Each glyph is 5 pixels wide and 8 rows tall. It sits in a 6x10 cell: one blank column to its right and two blank rows below it. Each character pixel is held for 3 clocks and each glyph row is drawn on 3 lines. The default grid therefore fills 576 clocks by 480 lines. Printable codes 0x20..0x7F select one of 96 glyphs. Every other code is drawn blank. A host write reaches the screen the next time the beam passes that cell. There is no tearing guard.

Top module: `vga_text_gen`

## Requirements
- R1: While reset is held, and during the first two clocks after it is released, video_o is 0 and both sync outputs are 1.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks. hsync_n_o is 0 for exactly H_SYNC clocks, from line position H_ACTIVE+H_FP, and 1 for the rest of the line.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. vsync_n_o is 0 for exactly V_SYNC whole lines, from line V_ACTIVE+V_FP, and it changes only at a line start.
- R4: The outputs for scan position (h, v) appear two clocks after the scan counter reaches it. For a text position, the cell is column h/(CELL_W*PIX_REP) and row v/(CELL_H*LINE_REP). The character pixel is (h mod (CELL_W*PIX_REP))/PIX_REP, and each character pixel is held PIX_REP clocks. Glyph bit 4 is the leftmost pixel.
- R5: A code c in 0x20..0x7F uses glyph index g = c-0x20. Row r (0..7) of glyph g is 0 when g = 0. Otherwise it is the low 5 bits of ((g + 7*r) XOR (g >> 5)). This pattern is the ROM content.
- R6: The sixth and later pixel columns of each cell are always 0.
- R7: Each glyph row is shown on LINE_REP consecutive lines: the glyph row is (v mod (CELL_H*LINE_REP))/LINE_REP. Glyph rows 8 and 9 of every cell are always 0.
- R8: video_o is 0 at every position with h >= COLS*CELL_W*PIX_REP or v >= ROWS*CELL_H*LINE_REP, and therefore throughout both sync pulses.
- R9: A cell whose code is below 0x20 or has bit 7 set is drawn entirely 0.
- R10: A write with wr_en=1 stores wr_data into the cell at address row*COLS+col. The write is accepted during reset as well. The new code is shown from the next scan of that cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset of the timing and pipeline |
| wr_en | input | 1 | Host write strobe for the character buffer |
| wr_addr | input | $clog2(COLS*ROWS) | Cell address, row*COLS+col |
| wr_data | input | 8 | Character code to store |
| video_o | output | 1 | Monochrome pixel |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |

## Verification
The bench builds the block as an 8 by 4 grid. It keeps the default 6x10 cell and the 3x pixel and line replication. The porches are shortened to a 170-clock line and a 130-line frame. This lets four complete frames run, with a rewrite of every cell during vertical blanking of the second frame. The active width (150) and height (122) are set a little larger than the text area (144 by 120). The forced-blank margin to the right of and below the text is therefore exercised, along with the sync pulses, every spacing column and row, and codes on both sides of the printable range.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;
    localparam int GLYPH_W    = 5;
    localparam int GLYPH_H    = 8;
    localparam int FIRST_CODE = 32;
    localparam int NUM_GLYPHS = 96;
    localparam int CODE_W     = 8;
    localparam int GIDX_W     = 7;
    localparam int GROW_W     = 3;
    localparam int GCOL_W     = 3;
    localparam int ROM_AW     = GIDX_W + GROW_W;

    typedef logic [GLYPH_W-1:0] glyph_bits_t;

    // Computed glyph pattern: index 0 (space) is blank.
    function automatic glyph_bits_t glyph_pattern(input int idx, input int row);
        int v;
        if (idx == 0) begin
            v = 0;
        end else begin
            v = ((idx + 7 * row) ^ (idx >> 5)) & 31;
        end
        return glyph_bits_t'(v);
    endfunction
endpackage

// File: rtl/vga_sync_timer.sv
module vga_sync_timer #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          line_end,
    output logic          frame_end,
    output logic          hsync_n,
    output logic          vsync_n
);
    localparam int HS_START = H_ACTIVE + H_FP;
    localparam int HS_END   = HS_START + H_SYNC;
    localparam int VS_START = V_ACTIVE + V_FP;
    localparam int VS_END   = VS_START + V_SYNC;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (scan_q.h == HW'(H_TOTAL - 1)) begin
            scan_d.h = '0;
            if (scan_q.v == VW'(V_TOTAL - 1)) begin
                scan_d.v = '0;
            end else begin
                scan_d.v = scan_q.v + 1'b1;
            end
        end else begin
            scan_d.h = scan_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign h_pos     = scan_q.h;
    assign v_pos     = scan_q.v;
    assign line_end  = (scan_q.h == HW'(H_TOTAL - 1));
    assign frame_end = line_end && (scan_q.v == VW'(V_TOTAL - 1));
    assign hsync_n   = !((scan_q.h >= HW'(HS_START)) && (scan_q.h < HW'(HS_END)));
    assign vsync_n   = !((scan_q.v >= VW'(VS_START)) && (scan_q.v < VW'(VS_END)));
endmodule

// File: rtl/vga_cell_mapper.sv
module vga_cell_mapper #(
    parameter int COLS     = 32,
    parameter int ROWS     = 16,
    parameter int CELL_W   = 6,
    parameter int CELL_H   = 10,
    parameter int PIX_REP  = 3,
    parameter int LINE_REP = 3,
    localparam int CW      = $clog2(COLS + 1),
    localparam int RW      = $clog2(ROWS + 1),
    localparam int SXW     = $clog2(CELL_W),
    localparam int SYW     = $clog2(CELL_H)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_end,
    input  logic           frame_end,
    output logic [CW-1:0]  col,
    output logic [RW-1:0]  row,
    output logic [SXW-1:0] sub_x,
    output logic [SYW-1:0] sub_y,
    output logic           in_text
);
    localparam int RXW = (PIX_REP  > 1) ? $clog2(PIX_REP)  : 1;
    localparam int RYW = (LINE_REP > 1) ? $clog2(LINE_REP) : 1;

    typedef struct packed {
        logic [RXW-1:0] rep_x;
        logic [SXW-1:0] sub_x;
        logic [CW-1:0]  col;
        logic [RYW-1:0] rep_y;
        logic [SYW-1:0] sub_y;
        logic [RW-1:0]  row;
    } cell_pos_t;

    cell_pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (line_end) begin
            pos_d.rep_x = '0;
            pos_d.sub_x = '0;
            pos_d.col   = '0;
            if (frame_end) begin
                pos_d.rep_y = '0;
                pos_d.sub_y = '0;
                pos_d.row   = '0;
            end else if (pos_q.row != RW'(ROWS)) begin
                if (pos_q.rep_y == RYW'(LINE_REP - 1)) begin
                    pos_d.rep_y = '0;
                    if (pos_q.sub_y == SYW'(CELL_H - 1)) begin
                        pos_d.sub_y = '0;
                        pos_d.row   = pos_q.row + 1'b1;
                    end else begin
                        pos_d.sub_y = pos_q.sub_y + 1'b1;
                    end
                end else begin
                    pos_d.rep_y = pos_q.rep_y + 1'b1;
                end
            end
        end else if (pos_q.col != CW'(COLS)) begin
            if (pos_q.rep_x == RXW'(PIX_REP - 1)) begin
                pos_d.rep_x = '0;
                if (pos_q.sub_x == SXW'(CELL_W - 1)) begin
                    pos_d.sub_x = '0;
                    pos_d.col   = pos_q.col + 1'b1;
                end else begin
                    pos_d.sub_x = pos_q.sub_x + 1'b1;
                end
            end else begin
                pos_d.rep_x = pos_q.rep_x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign col     = pos_q.col;
    assign row     = pos_q.row;
    assign sub_x   = pos_q.sub_x;
    assign sub_y   = pos_q.sub_y;
    assign in_text = (pos_q.col != CW'(COLS)) && (pos_q.row != RW'(ROWS));
endmodule

// File: rtl/vga_char_buffer.sv
module vga_char_buffer #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            cells[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        rd_data_q <= cells[rd_addr];
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/vga_glyph_rom.sv
module vga_glyph_rom
    import vga_text_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [GROW_W-1:0] row,
    output glyph_bits_t       bits
);
    glyph_bits_t       glyph_tab [NUM_GLYPHS*GLYPH_H];
    logic              printable;
    logic [GIDX_W-1:0] gidx;
    logic [ROM_AW-1:0] addr;

    for (genvar g = 0; g < NUM_GLYPHS; g++) begin : g_glyph
        for (genvar r = 0; r < GLYPH_H; r++) begin : g_row
            assign glyph_tab[g*GLYPH_H + r] = glyph_pattern(g, r);
        end
    end

    always_comb begin
        printable = (code >= CODE_W'(FIRST_CODE)) && !code[CODE_W-1];
        gidx      = GIDX_W'(code - CODE_W'(FIRST_CODE));
        addr      = printable ? {gidx, row} : '0;
        bits      = printable ? glyph_tab[addr] : '0;
    end
endmodule

// File: rtl/vga_text_gen.sv
module vga_text_gen
    import vga_text_pkg::*;
#(
    parameter int COLS     = 32,
    parameter int ROWS     = 16,
    parameter int CELL_W   = 6,
    parameter int CELL_H   = 10,
    parameter int PIX_REP  = 3,
    parameter int LINE_REP = 3,
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    localparam int DEPTH   = COLS * ROWS,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          video_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int CW      = $clog2(COLS + 1);
    localparam int RW      = $clog2(ROWS + 1);
    localparam int SXW     = $clog2(CELL_W);
    localparam int SYW     = $clog2(CELL_H);
    localparam int TEXT_W  = COLS * CELL_W * PIX_REP;
    localparam int TEXT_H  = ROWS * CELL_H * LINE_REP;

    typedef struct packed {
        logic              lit;
        logic [GCOL_W-1:0] gcol;
        logic [GROW_W-1:0] grow;
        logic              hs_n;
        logic              vs_n;
    } fetch_t;

    typedef struct packed {
        logic video;
        logic hs_n;
        logic vs_n;
    } out_t;

    logic [HW-1:0]  tmr_h;
    logic [VW-1:0]  tmr_v;
    logic           tmr_line_end;
    logic           tmr_frame_end;
    logic           tmr_hs_n;
    logic           tmr_vs_n;
    logic [CW-1:0]  map_col;
    logic [RW-1:0]  map_row;
    logic [SXW-1:0] map_sub_x;
    logic [SYW-1:0] map_sub_y;
    logic           map_in_text;
    logic [AW-1:0]  rd_addr;
    logic [7:0]     rd_code;
    glyph_bits_t    glyph_row_bits;
    glyph_bits_t    glyph_shifted;

    fetch_t fetch_d, fetch_q;
    out_t   out_d, out_q;

    vga_sync_timer #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .h_pos     (tmr_h),
        .v_pos     (tmr_v),
        .line_end  (tmr_line_end),
        .frame_end (tmr_frame_end),
        .hsync_n   (tmr_hs_n),
        .vsync_n   (tmr_vs_n)
    );

    vga_cell_mapper #(
        .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
        .PIX_REP(PIX_REP), .LINE_REP(LINE_REP)
    ) u_mapper (
        .clk       (clk),
        .rst       (rst),
        .line_end  (tmr_line_end),
        .frame_end (tmr_frame_end),
        .col       (map_col),
        .row       (map_row),
        .sub_x     (map_sub_x),
        .sub_y     (map_sub_y),
        .in_text   (map_in_text)
    );

    always_comb begin
        if (map_in_text) begin
            rd_addr = AW'(int'(map_row) * COLS + int'(map_col));
        end else begin
            rd_addr = '0;
        end
    end

    vga_char_buffer #(
        .DEPTH(DEPTH), .DW(8)
    ) u_buffer (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_code)
    );

    vga_glyph_rom u_rom (
        .code (rd_code),
        .row  (fetch_q.grow),
        .bits (glyph_row_bits)
    );

    // Stage 1: cell position and sync, aligned with the buffer read.
    always_comb begin
        fetch_d.lit  = map_in_text
                    && (map_sub_x < SXW'(GLYPH_W))
                    && (map_sub_y < SYW'(GLYPH_H));
        fetch_d.gcol = GCOL_W'(map_sub_x);
        fetch_d.grow = GROW_W'(map_sub_y);
        fetch_d.hs_n = tmr_hs_n;
        fetch_d.vs_n = tmr_vs_n;
    end

    // Stage 2: pick the glyph pixel, leftmost column is the MSB.
    always_comb begin
        glyph_shifted = glyph_row_bits << fetch_q.gcol;
        out_d.video   = fetch_q.lit && glyph_shifted[GLYPH_W-1];
        out_d.hs_n    = fetch_q.hs_n;
        out_d.vs_n    = fetch_q.vs_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '{lit: 1'b0, gcol: '0, grow: '0, hs_n: 1'b1, vs_n: 1'b1};
            out_q   <= '{video: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
        end else begin
            fetch_q <= fetch_d;
            out_q   <= out_d;
        end
    end

    assign video_o   = out_q.video;
    assign hsync_n_o = out_q.hs_n;
    assign vsync_n_o = out_q.vs_n;
endmodule

// File: rtl/vga_text_chk.sv
module vga_text_chk #(
    parameter int H_TOTAL = 800,
    parameter int H_SYNC  = 96,
    parameter int TEXT_W  = 576,
    parameter int TEXT_H  = 480,
    parameter int CELL_W  = 6,
    parameter int HW      = 10,
    parameter int VW      = 10,
    parameter int SXW     = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           video_o,
    input logic           hsync_n_o,
    input logic           vsync_n_o,
    input logic [HW-1:0]  tmr_h,
    input logic [VW-1:0]  tmr_v,
    input logic           tmr_vs_n,
    input logic           map_in_text,
    input logic [SXW-1:0] map_sub_x
);
    int hs_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_len <= 0;
        end else if (!hsync_n_o) begin
            hs_len <= hs_len + 1;
        end else begin
            hs_len <= 0;
        end
    end

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (int'(tmr_h) == H_TOTAL - 1) |=> (tmr_h == '0)); // R2

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n_o) |-> (hs_len == H_SYNC)); // R2

    AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
        (tmr_vs_n != $past(tmr_vs_n)) |-> (tmr_h == '0)); // R3

    AST_TEXT_INSIDE: assert property (@(posedge clk) disable iff (rst)
        map_in_text |-> ((int'(tmr_h) < TEXT_W) && (int'(tmr_v) < TEXT_H))); // R8

    AST_DARK_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n_o || !vsync_n_o) |-> !video_o); // R8

    AST_SUBCOL_RANGE: assert property (@(posedge clk) disable iff (rst)
        map_in_text |-> (int'(map_sub_x) < CELL_W)); // R6
endmodule

bind vga_text_gen vga_text_chk #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .TEXT_W(TEXT_W), .TEXT_H(TEXT_H),
    .CELL_W(CELL_W), .HW(HW), .VW(VW), .SXW(SXW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .video_o     (video_o),
    .hsync_n_o   (hsync_n_o),
    .vsync_n_o   (vsync_n_o),
    .tmr_h       (tmr_h),
    .tmr_v       (tmr_v),
    .tmr_vs_n    (tmr_vs_n),
    .map_in_text (map_in_text),
    .map_sub_x   (map_sub_x)
);

// File: tb/sim_vga_text_gen.sv
module sim_vga_text_gen;
    localparam int CLK_PERIOD = 10;
    localparam int COLS     = 8;
    localparam int ROWS     = 4;
    localparam int CELL_W   = 6;
    localparam int CELL_H   = 10;
    localparam int PIX_REP  = 3;
    localparam int LINE_REP = 3;
    localparam int H_ACT = 150, H_FP = 4, H_SY = 8, H_BP = 8;
    localparam int V_ACT = 122, V_FP = 2, V_SY = 2, V_BP = 4;
    localparam int H_TOT  = H_ACT + H_FP + H_SY + H_BP;
    localparam int V_TOT  = V_ACT + V_FP + V_SY + V_BP;
    localparam int DEPTH  = COLS * ROWS;
    localparam int AW     = $clog2(DEPTH);
    localparam int TEXT_W = COLS * CELL_W * PIX_REP;
    localparam int TEXT_H = ROWS * CELL_H * LINE_REP;
    localparam int FRAMES = 4;
    localparam int RUN    = FRAMES * H_TOT * V_TOT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          video, hs_n, vs_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    int cellmem [DEPTH];
    bit touched [DEPTH];

    vga_text_gen #(
        .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
        .PIX_REP(PIX_REP), .LINE_REP(LINE_REP),
        .H_ACTIVE(H_ACT), .H_FP(H_FP), .H_SYNC(H_SY), .H_BP(H_BP),
        .V_ACTIVE(V_ACT), .V_FP(V_FP), .V_SYNC(V_SY), .V_BP(V_BP)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .video_o   (video),
        .hsync_n_o (hs_n),
        .vsync_n_o (vs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R5 glyph pattern
    function automatic int glyph(input int g, input int r);
        if (g == 0) return 0;
        return ((g + 7 * r) ^ (g >> 5)) & 31;
    endfunction

    function automatic int first_code(input int i);
        case (i)
            3:       return 8'h05;
            5:       return 8'hA1;
            10:      return 8'h7F;
            12:      return 8'h20;
            14:      return 8'h1F;
            17:      return 8'h80;
            default: return 8'h21 + (i * 11) % 95;
        endcase
    endfunction

    function automatic int second_code(input int i);
        case (i)
            1:       return 8'h1F;
            2:       return 8'h80;
            6:       return 8'hFF;
            9:       return 8'h20;
            default: return (i % 4 == 0) ? (8'h7F - i) : (8'h40 + i);
        endcase
    endfunction

    task automatic check_at(input int p);
        int    h, v, col, px, row, ry, code;
        int    e_hs, e_vs, e_vid;
        string tag_s, tag_v;
        bit    bad;
        e_hs = 1; e_vs = 1; e_vid = 0;
        tag_s = "R1"; tag_v = "R1";
        if (p >= 0) begin
            h = p % H_TOT;
            v = (p / H_TOT) % V_TOT;
            e_hs = (h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SY) ? 0 : 1;
            e_vs = (v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SY) ? 0 : 1;
            tag_s = "";
            if (h >= TEXT_W || v >= TEXT_H) begin
                tag_v = "R8";
            end else begin
                col  = h / (CELL_W * PIX_REP);
                px   = (h % (CELL_W * PIX_REP)) / PIX_REP;
                row  = v / (CELL_H * LINE_REP);
                ry   = (v % (CELL_H * LINE_REP)) / LINE_REP;
                code = cellmem[row * COLS + col];
                if (px >= 5) tag_v = "R6";
                else if (ry >= 8) tag_v = "R7";
                else if (code < 32 || code >= 128) tag_v = "R9";
                else begin
                    tag_v = touched[row * COLS + col] ? "R10" : "R4,R5";
                    e_vid = (glyph(code - 32, ry) >> (4 - px)) & 1;
                end
            end
        end
        vectors++;
        bad = 1'b0;
        if (hs_n !== 1'(e_hs)) begin
            bad = 1'b1;
            $display("FAIL %s hsync at pixel %0d: got %0b expected %0b",
                     (p < 0) ? "R1" : "R2", p, hs_n, e_hs);
        end
        if (vs_n !== 1'(e_vs)) begin
            bad = 1'b1;
            $display("FAIL %s vsync at pixel %0d: got %0b expected %0b",
                     (p < 0) ? "R1" : "R3", p, vs_n, e_vs);
        end
        if (video !== 1'(e_vid)) begin
            bad = 1'b1;
            $display("FAIL %s video at pixel %0d: got %0b expected %0b",
                     tag_v, p, video, e_vid);
        end
        if (bad) misses++;
        if (tag_s.len() > 100) $display("unused");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) touched[i] = 1'b0;
        repeat (2) @(negedge clk);
        // R10: load every cell while reset is still held
        for (int i = 0; i < DEPTH; i++) begin
            wr_en      = 1'b1;
            wr_addr    = AW'(i);
            wr_data    = 8'(first_code(i));
            cellmem[i] = first_code(i);
            @(negedge clk);
            check_at(-1); // R1 during reset
        end
        wr_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_at(-1); // R1
        end
        rst = 1'b0;
        for (int n = 1; n <= RUN; n++) begin
            int h_now, v_now, f_now;
            @(posedge clk);
            @(negedge clk);
            check_at(n - 2);
            h_now = n % H_TOT;
            v_now = (n / H_TOT) % V_TOT;
            f_now = n / (H_TOT * V_TOT);
            // R10: rewrite every cell during the blanking of frame 1
            if (f_now == 1 && v_now == TEXT_H + 3 && h_now < DEPTH) begin
                wr_en            = 1'b1;
                wr_addr          = AW'(h_now);
                wr_data          = 8'(second_code(h_now));
                cellmem[h_now]   = second_code(h_now);
                touched[h_now]   = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule